// File: doc/BRIEF.md
# Teletype Serial Character Port

This block links a processor to a teletype-style terminal over a single half-duplex serial line pair. One nine-stage shift register is shared by both directions. For reception it starts filled with mark and collects line samples at its top end. For transmission it holds the byte written by the processor, and that byte drains from its bottom end. End of character is found by watching a marker reach the lowest stage, never by counting bits. A busy flag covers the whole character. A ready flag tells the processor that a received character may be read or that the line is free for the next write.

The processor writes a byte with a one-cycle write strobe and reads a byte with a one-cycle read strobe. The read strobe also acknowledges the character. Ready can be polled directly or turned into an interrupt request through a mask flag. The bit period is a fixed number of system clocks set by a parameter. The receiver takes its first sample half a bit period after it sees the start edge, and every later sample one full bit period after the one before.

Top module: `tty_serial_port`

## Requirements
- R1: After synchronous reset the transmit line is at mark (1), busy, ready, irq and frame_err are 0, rd_byte is 0, and the interrupt mask is clear.
- R2: A write strobe accepted while busy is 0 makes busy 1 and clears ready from the next cycle. It drives the transmit line to space (0) for one bit period, then sends the eight data bits least significant first for one bit period each, then holds mark (1). The line stays at mark whenever busy is 0.
- R3: A transmitted character ends one full stop-bit period after the last data bit, ten bit periods after the write edge. At that edge busy falls and ready rises. Ready is never 1 while busy is 1, and it rises only as busy falls.
- R4: A write strobe while busy is 1 is ignored. The character in flight goes out unchanged.
- R5: With busy and ready both 0, a falling edge on the receive line starts a reception. The receiver samples at mid-bit. Once the start bit has reached the lowest buffer stage, a mark seen at mid stop bit sets ready, and the received byte can then be read.
- R6: While ready is 1, a falling edge on the receive line starts no reception. The unread byte stays in the buffer.
- R7: A space seen at mid stop bit sets frame_err and leaves ready at 0. frame_err clears when the next reception starts or when a write is accepted.
- R8: If the first mid-bit sample after a start edge reads mark, the reception is dropped. Busy returns to 0 and ready stays 0.
- R9: rd_byte shows the buffered byte only while rd_stb is 1 and is 0 otherwise. When rd_ascii is 1, bit 7 of rd_byte is forced to 1. The cycle after rd_stb, ready is 0.
- R10: irq is 1 exactly when ready is 1 and the mask flag is 1. A pulse on mask_wr loads the mask flag from mask_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial receive line, 1 = mark |
| tx_line | output | 1 | Serial transmit line, 1 = mark |
| wr_stb | input | 1 | Output write strobe |
| wr_byte | input | DATA_BITS | Byte to transmit |
| rd_stb | input | 1 | Read strobe and acknowledge |
| rd_ascii | input | 1 | Force the top data bit to 1 on read |
| rd_byte | output | DATA_BITS | Buffered byte while rd_stb is 1, else 0 |
| mask_wr | input | 1 | Load the interrupt mask |
| mask_val | input | 1 | New interrupt mask value |
| busy | output | 1 | Character transfer in progress |
| ready | output | 1 | Character received or transmitter free |
| irq | output | 1 | Interrupt request |
| frame_err | output | 1 | Last reception had a space at stop time |

## Verification
The assertions check on every cycle that ready and busy are never both 1 and that ready rises only as busy falls. They also check that the line idles at mark, that an accepted write starts with a space, that a write during a transfer leaves the buffer and the line untouched, and that a framing error never arrives with ready. The exact bit sequence of a frame, mid-bit sampling on receive, rejection of a short start glitch, ASCII read formatting and the retention of an unread byte can only be shown by the bench's scenarios. There the transmit line, busy and ready are compared cycle by cycle against a counting model.

// File: rtl/tty_pkg.sv
package tty_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_DATA,
    ST_RX_STOP,
    ST_TX_DATA,
    ST_TX_STOP
  } tty_state_e;

endpackage

// File: rtl/tty_rx_sync.sv
module tty_rx_sync #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic line_fall
);

  logic [SYNC_DEPTH-1:0] chain_q;
  logic                  prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[SYNC_DEPTH-2:0], line_in};
      prev_q  <= chain_q[SYNC_DEPTH-1];
    end
  end

  assign line_s    = chain_q[SYNC_DEPTH-1];
  assign line_fall = prev_q & ~chain_q[SYNC_DEPTH-1];

endmodule

// File: rtl/tty_bit_timer.sv
module tty_bit_timer #(
  parameter int CLK_DIV = 16,
  parameter int TW      = $clog2(CLK_DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          tick
);

  localparam logic [TW-1:0] RELOAD = TW'(CLK_DIV - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RELOAD;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= RELOAD;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = run && !load && (cnt_q == '0);

endmodule

// File: rtl/tty_shift_buf.sv
module tty_shift_buf #(
  parameter int STAGES = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset,
  input  logic              load,
  input  logic [STAGES-1:0] load_val,
  input  logic              shift,
  input  logic              shift_in,
  output logic [STAGES-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stage_q;
    logic upper;

    if (i == STAGES - 1) begin : g_top
      assign upper = shift_in;
    end else begin : g_mid
      assign upper = q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst || preset)  stage_q <= 1'b1;
      else if (load)      stage_q <= load_val[i];
      else if (shift)     stage_q <= upper;
    end

    assign q[i] = stage_q;
  end

endmodule

// File: rtl/tty_serial_port.sv
module tty_serial_port
  import tty_pkg::*;
#(
  parameter int CLK_DIV    = 1085,
  parameter int DATA_BITS  = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  output logic                 tx_line,
  input  logic                 wr_stb,
  input  logic [DATA_BITS-1:0] wr_byte,
  input  logic                 rd_stb,
  input  logic                 rd_ascii,
  output logic [DATA_BITS-1:0] rd_byte,
  input  logic                 mask_wr,
  input  logic                 mask_val,
  output logic                 busy,
  output logic                 ready,
  output logic                 irq,
  output logic                 frame_err
);

  localparam int STAGES = DATA_BITS + 1;
  localparam int TW     = $clog2(CLK_DIV);
  localparam logic [TW-1:0]     FULL_LD  = TW'(CLK_DIV - 1);
  localparam logic [TW-1:0]     HALF_LD  = TW'(CLK_DIV / 2 - 1);
  localparam logic [STAGES-1:0] ALL_MARK = '1;
  localparam logic [STAGES-1:0] TX_LAST  = STAGES'(1);

  tty_state_e        state_q;
  logic              tx_q, ready_q, mask_q, ferr_q;
  logic              rx_s, rx_fall, tick;
  logic [STAGES-1:0] buf_q;
  logic              wr_go, rx_go, rx_false, tx_end;
  logic              buf_shift, shift_in, tmr_load;
  logic [TW-1:0]     tmr_val;

  tty_rx_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .line_in(rx_line),
    .line_s(rx_s), .line_fall(rx_fall)
  );

  tty_bit_timer #(.CLK_DIV(CLK_DIV), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .run(state_q != ST_IDLE), .tick(tick)
  );

  tty_shift_buf #(.STAGES(STAGES)) u_buf (
    .clk(clk), .rst(rst), .preset(rx_go), .load(wr_go),
    .load_val({1'b1, wr_byte}), .shift(buf_shift),
    .shift_in(shift_in), .q(buf_q)
  );

  // start conditions: a write has priority over a receive edge
  assign wr_go    = (state_q == ST_IDLE) && wr_stb;
  assign rx_go    = (state_q == ST_IDLE) && !wr_stb && rx_fall && !ready_q;
  assign tmr_load = wr_go || rx_go;
  assign tmr_val  = wr_go ? FULL_LD : HALF_LD;

  // first receive sample still at mark: drop the character
  assign rx_false = (state_q == ST_RX_DATA) && tick && (buf_q == ALL_MARK) && rx_s;
  // transmit marker sits alone in the lowest stage: ninth pulse
  assign tx_end   = (state_q == ST_TX_DATA) && tick && (buf_q == TX_LAST);

  assign buf_shift = ((state_q == ST_RX_DATA) && tick && !rx_false) ||
                     ((state_q == ST_TX_DATA) && tick && !tx_end);
  assign shift_in  = (state_q == ST_RX_DATA) ? rx_s : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tx_q    <= 1'b1;
      ready_q <= 1'b0;
      mask_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_val;
      if (rd_stb)  ready_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: begin
          if (wr_go) begin
            ready_q <= 1'b0;
            ferr_q  <= 1'b0;
            tx_q    <= 1'b0;
            state_q <= ST_TX_DATA;
          end else if (rx_go) begin
            ferr_q  <= 1'b0;
            state_q <= ST_RX_DATA;
          end
        end
        ST_RX_DATA: begin
          if (rx_false)      state_q <= ST_IDLE;
          else if (!tick && !buf_q[0]) state_q <= ST_RX_STOP;
        end
        ST_RX_STOP: begin
          if (tick) begin
            if (rx_s) ready_q <= 1'b1;
            else      ferr_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_TX_DATA: begin
          if (tx_end) begin
            tx_q    <= 1'b1;
            state_q <= ST_TX_STOP;
          end else if (tick) begin
            tx_q <= buf_q[0];
          end
        end
        ST_TX_STOP: begin
          if (tick) begin
            ready_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_line   = tx_q;
  assign busy      = (state_q != ST_IDLE);
  assign ready     = ready_q;
  assign irq       = ready_q & mask_q;
  assign frame_err = ferr_q;
  assign rd_byte   = rd_stb ? {rd_ascii | buf_q[STAGES-1], buf_q[STAGES-2:1]} : '0;

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);  // R2
  AST_START_SPACE: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_stb) |=> (busy && !tx_line));  // R2
  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready);  // R3
  AST_READY_ON_END: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(busy) && !busy));  // R3
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_stb && !tick) |=> ($stable(buf_q) && $stable(tx_line)));  // R4
  AST_FERR_NO_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err) |-> !ready);  // R7

endmodule

// File: tb/tty_serial_port_test.sv
module tty_serial_port_test;

  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       rd_stb = 1'b0;
  logic       rd_ascii = 1'b0;
  logic       mask_wr = 1'b0;
  logic       mask_val = 1'b0;
  logic       tx_line, busy, ready, irq, frame_err;
  logic [7:0] rd_byte;

  int  n_checks = 0;
  int  n_fail   = 0;
  int  irq_bad  = 0;
  bit  done     = 1'b0;
  logic exp_mask = 1'b0;

  always #4 clk = ~clk;

  tty_serial_port #(.CLK_DIV(DIV), .DATA_BITS(8)) uut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .tx_line(tx_line),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_ascii(rd_ascii),
    .rd_byte(rd_byte), .mask_wr(mask_wr), .mask_val(mask_val),
    .busy(busy), .ready(ready), .irq(irq), .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R10: irq follows ready and the modelled mask on every clock
  always @(negedge clk) begin
    if (!rst && !done && (irq !== (ready & exp_mask))) irq_bad++;
  end

  task automatic set_mask(input logic v);
    @(negedge clk); mask_wr = 1'b1; mask_val = v; exp_mask <= v;
    @(negedge clk); mask_wr = 1'b0;
  endtask

  // transmit a byte and compare line, busy and ready every cycle
  task automatic send_tx(input logic [7:0] b, input bit inject, input string req);
    logic [9:0] bits;
    int bad;
    int first_bad;
    logic exp_tx, exp_busy, exp_ready;
    bits = {1'b1, b, 1'b0};
    bad = 0;
    first_bad = -1;
    @(negedge clk); wr_byte = b; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    for (int n = 0; n <= 10 * DIV; n++) begin
      exp_tx    = (n < 10 * DIV) ? bits[n / DIV] : 1'b1;
      exp_busy  = (n < 10 * DIV);
      exp_ready = (n >= 10 * DIV);
      if (tx_line !== exp_tx || busy !== exp_busy || ready !== exp_ready) begin
        bad++;
        if (first_bad < 0) first_bad = n;
      end
      if (inject && (n == 3 * DIV)) begin
        wr_byte = 8'hFF; wr_stb = 1'b1;
      end else begin
        wr_stb = 1'b0;
      end
      @(negedge clk);
    end
    check(bad == 0, req, $sformatf("tx frame %02h mismatching cycles (first at %0d)", b, first_bad), bad, 0);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    logic [9:0] bits;
    bits = {stop, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      rx_line = bits[k];
      repeat (DIV) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic ascii, output logic [7:0] val);
    @(negedge clk); rd_stb = 1'b1; rd_ascii = ascii;
    #1 val = rd_byte;
    @(negedge clk); rd_stb = 1'b0; rd_ascii = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(tx_line === 1'b1, "R1", "tx_line", tx_line, 1);
    check(busy === 1'b0 && ready === 1'b0, "R1", "busy/ready", {busy, ready}, 0);
    check(irq === 1'b0 && frame_err === 1'b0, "R1", "irq/frame_err", {irq, frame_err}, 0);
    check(rd_byte === 8'h00, "R1", "rd_byte", rd_byte, 0);

    // R2, R3 transmit frames, including all-zero and all-one bytes
    send_tx(8'hA5, 1'b0, "R2");
    check(irq === 1'b0, "R10", "irq with mask clear", irq, 0);
    send_tx(8'h00, 1'b0, "R2");
    send_tx(8'hFF, 1'b0, "R3");
    // R4 write during a transfer ignored
    send_tx(8'h3C, 1'b1, "R4");

    // R9 read strobe handling
    check(rd_byte === 8'h00, "R9", "rd_byte without strobe", rd_byte, 0);
    do_read(1'b0, got);
    check(ready === 1'b0, "R9", "ready after read", ready, 0);

    // R5 reception with interrupt enabled
    set_mask(1'b1);
    send_rx(8'h5A, 1'b1);
    check(ready === 1'b1 && busy === 1'b0, "R5", "ready/busy after rx", {ready, busy}, 2);
    check(irq === 1'b1, "R10", "irq with mask set", irq, 1);
    check(rd_byte === 8'h00, "R9", "rd_byte idle while ready", rd_byte, 0);

    // R6 second character while ready is ignored
    send_rx(8'h33, 1'b1);
    check(busy === 1'b0 && ready === 1'b1, "R6", "state after blocked rx", {busy, ready}, 1);
    do_read(1'b1, got);
    check(got === 8'hDA, "R9", "ascii read", got, 8'hDA);
    check(ready === 1'b0 && irq === 1'b0, "R9", "ready/irq after read", {ready, irq}, 0);
    do_read(1'b0, got);
    check(got === 8'h5A, "R6", "retained byte", got, 8'h5A);

    // R5 another pattern
    send_rx(8'hC3, 1'b1);
    do_read(1'b0, got);
    check(got === 8'hC3, "R5", "rx byte", got, 8'hC3);

    // R7 framing error
    send_rx(8'h81, 1'b0);
    check(frame_err === 1'b1, "R7", "frame_err set", frame_err, 1);
    check(ready === 1'b0 && busy === 1'b0, "R7", "ready/busy after bad stop", {ready, busy}, 0);
    send_tx(8'h12, 1'b0, "R2");
    check(frame_err === 1'b0, "R7", "frame_err cleared by write", frame_err, 0);
    do_read(1'b0, got);

    // R8 short start glitch
    rx_line = 1'b0;
    repeat (2) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * DIV) @(negedge clk);
    check(busy === 1'b0 && ready === 1'b0, "R8", "after glitch", {busy, ready}, 0);
    send_rx(8'h7E, 1'b1);
    do_read(1'b0, got);
    check(got === 8'h7E, "R8", "rx after glitch", got, 8'h7E);

    check(irq_bad == 0, "R10", "irq mismatching cycles", irq_bad, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule